// File: doc/BRIEF.md
# Relocatable Memory Window Decoder

This block places a relocatable memory array in a 24-bit system address map. A base register sets where the array begins. Reset fills that register from a stored default value, and a runtime write can change it later. Every bus address first has its upper bits replaced by copies of one lower bit, because the processor only drives addresses in that mirrored form. The block then tests whether the address falls inside the array window. It produces an array select and the byte offset into the array.

A fixed register block has priority over the array. When a bus address hits both the array window and the register block, the register access goes ahead. The array access is dropped and is reported on a one-cycle ignored flag. A base that lies in the part of the map the processor cannot reach disables the array completely, until the register is given a reachable value again. All outputs are registered and appear one cycle after the address, together with a copy of the valid strobe.

Top module: `relocWindowDec`

## Requirements
- R1: While `rstN` is low, `outValid`, `arraySel`, `ignoredAccess` and `arrayOffset` are all zero.
- R2: On the first clock edge after reset is released, the base register takes the value of `shadowBase`, and no access sampled on that edge selects the array. A write on that same edge is dropped.
- R3: An access selects the array when its mirrored address lies in the range base to base + ARRAY_BYTES - 1 inclusive. `arraySel` goes high on the edge after the address was sampled. With ARRAY_BYTES = 16384 and base 0x012000, the addresses 0x012000 and 0x015FFF hit, and 0x011FFF and 0x016000 miss.
- R4: `arrayOffset` equals the mirrored address minus the base, truncated to log2(ARRAY_BYTES) bits.
- R5: The base is aligned to 2 KB. Bits [10:0] of a written value are treated as zero, so a write of 0x0207FF gives base 0x020000.
- R6: Address bits [23:20] are replaced by bit 19 before the compare. With base 0xFFC000, bus address 0x0FC010 hits with offset 0x10, and 0x07C010 misses.
- R7: If base bits [23:19] are not all equal, the array is unreachable and `arraySel` never asserts. Examples are bases 0x100000 and 0xF7F800.
- R8: A window hit that arrives with `regBlockHit` high gives `arraySel` = 0 and `ignoredAccess` = 1 for that one cycle.
- R9: `regBlockHit` outside the window, or with `busValid` low, never raises `ignoredAccess`.
- R10: `outValid` is `busValid` delayed by one cycle. With `busValid` low, neither `arraySel` nor `ignoredAccess` asserts.
- R11: A write through `baseWrEn`/`baseWrData` is used from the next access onward. A change on `shadowBase` has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| shadowBase | input | 24 | Stored default base, loaded after reset |
| baseWrEn | input | 1 | Runtime base register write enable |
| baseWrData | input | 24 | Runtime base value |
| busAddr | input | 24 | Bus address |
| busValid | input | 1 | Bus address valid strobe |
| regBlockHit | input | 1 | Address hits the fixed register block |
| outValid | output | 1 | Registered copy of busValid |
| arraySel | output | 1 | Array selected |
| arrayOffset | output | 14 | Byte offset inside the array |
| ignoredAccess | output | 1 | Array hit suppressed by the register block |

## Verification
The base register is the only long-lived state in this block, so a fault in it appears as a shifted window. That shows up at the window edges, at an offset that is off by a fixed amount, or at a select that fires for a base that should be unreachable. Any of these is visible on the very next access. A wrong load sequence after reset shows up on the first or second access: either a select on the load edge, or an old base still in use. The checks are therefore placed at both edges of every window, one address past each edge, and on the first cycles after reset.

// File: rtl/relocWindowDecPkg.sv
package relocWindowDecPkg;
  typedef struct packed {
    logic loadShadow;
    logic writeBase;
    logic baseReady;
  } ctrlStrobes_t;
endpackage

// File: rtl/relocWindowCtrl.sv
module relocWindowCtrl
  import relocWindowDecPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         baseWrEn,
  output ctrlStrobes_t strobes
);
  logic loadPending;
  logic ready;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadPending <= 1'b1;
      ready       <= 1'b0;
    end else if (loadPending) begin
      loadPending <= 1'b0;
      ready       <= 1'b1;
    end
  end

  always_comb begin
    strobes.loadShadow = loadPending;
    strobes.writeBase  = baseWrEn & ~loadPending;
    strobes.baseReady  = ready;
  end

  p_load_once_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadShadow |=> !strobes.loadShadow && strobes.baseReady);
  p_no_write_on_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.loadShadow && strobes.writeBase));
endmodule

// File: rtl/relocWindowPath.sv
module relocWindowPath
  import relocWindowDecPkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int ARRAY_BYTES = 16384,
  parameter int ALIGN_BITS  = 11,
  parameter int MIRROR_BIT  = 19,
  localparam int OFF_W      = $clog2(ARRAY_BYTES),
  localparam int TOP_W      = ADDR_W - ALIGN_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] shadowBase,
  input  logic [ADDR_W-1:0] baseWrData,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busValid,
  input  logic              regBlockHit,
  output logic              outValid,
  output logic              arraySel,
  output logic [OFF_W-1:0]  arrayOffset,
  output logic              ignoredAccess
);
  localparam logic [ADDR_W-1:0] SIZE_V = ADDR_W'(ARRAY_BYTES);

  logic [TOP_W-1:0]  baseTop;
  logic [ADDR_W-1:0] baseFull;
  logic [ADDR_W-1:0] effAddr;
  logic [ADDR_W-1:0] diff;
  logic              baseReachable;
  logic              windowHit;

  // base register, upper bits only (alignment)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    baseTop <= '0;
    else if (strobes.loadShadow)  baseTop <= shadowBase[ADDR_W-1:ALIGN_BITS];
    else if (strobes.writeBase)   baseTop <= baseWrData[ADDR_W-1:ALIGN_BITS];
  end

  assign baseFull = {baseTop, {ALIGN_BITS{1'b0}}};

  // mirror upper address bits from MIRROR_BIT
  genvar gi;
  generate
    for (gi = 0; gi < ADDR_W; gi++) begin : g_mirror
      if (gi > MIRROR_BIT) begin : g_up
        assign effAddr[gi] = busAddr[MIRROR_BIT];
      end else begin : g_low
        assign effAddr[gi] = busAddr[gi];
      end
    end
  endgenerate

  assign baseReachable = (&baseFull[ADDR_W-1:MIRROR_BIT]) | ~(|baseFull[ADDR_W-1:MIRROR_BIT]);
  assign diff          = effAddr - baseFull;
  assign windowHit     = busValid & strobes.baseReady & baseReachable &
                         (effAddr >= baseFull) & (diff < SIZE_V);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid      <= 1'b0;
      arraySel      <= 1'b0;
      arrayOffset   <= '0;
      ignoredAccess <= 1'b0;
    end else begin
      outValid      <= busValid;
      arraySel      <= windowHit & ~regBlockHit;
      arrayOffset   <= diff[OFF_W-1:0];
      ignoredAccess <= windowHit & regBlockHit;
    end
  end

  p_sel_excl_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(arraySel && ignoredAccess));
  p_reg_priority_r8: assert property (@(posedge clk) disable iff (!rstN)
    regBlockHit |=> !arraySel);
  p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rstN)
    busValid |=> outValid);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |=> !outValid && !arraySel && !ignoredAccess);
  p_unreachable_r7: assert property (@(posedge clk) disable iff (!rstN)
    !baseReachable |=> !arraySel);
  p_no_sel_on_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadShadow |=> !arraySel && !ignoredAccess);
endmodule

// File: rtl/relocWindowDec.sv
module relocWindowDec
  import relocWindowDecPkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int ARRAY_BYTES = 16384,
  parameter int ALIGN_BITS  = 11,
  parameter int MIRROR_BIT  = 19,
  localparam int OFF_W      = $clog2(ARRAY_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] shadowBase,
  input  logic              baseWrEn,
  input  logic [ADDR_W-1:0] baseWrData,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busValid,
  input  logic              regBlockHit,
  output logic              outValid,
  output logic              arraySel,
  output logic [OFF_W-1:0]  arrayOffset,
  output logic              ignoredAccess
);
  ctrlStrobes_t strobes;

  relocWindowCtrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .baseWrEn (baseWrEn),
    .strobes  (strobes)
  );

  relocWindowPath #(
    .ADDR_W      (ADDR_W),
    .ARRAY_BYTES (ARRAY_BYTES),
    .ALIGN_BITS  (ALIGN_BITS),
    .MIRROR_BIT  (MIRROR_BIT)
  ) i_path (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .shadowBase    (shadowBase),
    .baseWrData    (baseWrData),
    .busAddr       (busAddr),
    .busValid      (busValid),
    .regBlockHit   (regBlockHit),
    .outValid      (outValid),
    .arraySel      (arraySel),
    .arrayOffset   (arrayOffset),
    .ignoredAccess (ignoredAccess)
  );
endmodule

// File: tb/test_relocWindowDec.sv
module test_relocWindowDec;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] shadowBase = 24'h012000;
  logic        baseWrEn = 1'b0;
  logic [23:0] baseWrData = '0;
  logic [23:0] busAddr = '0;
  logic        busValid = 1'b0;
  logic        regBlockHit = 1'b0;
  logic        outValid, arraySel, ignoredAccess;
  logic [13:0] arrayOffset;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  relocWindowDec i_relocWindowDec (
    .clk(clk), .rstN(rstN), .shadowBase(shadowBase), .baseWrEn(baseWrEn),
    .baseWrData(baseWrData), .busAddr(busAddr), .busValid(busValid),
    .regBlockHit(regBlockHit), .outValid(outValid), .arraySel(arraySel),
    .arrayOffset(arrayOffset), .ignoredAccess(ignoredAccess)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one access: drive at a falling edge, check at the next falling edge
  task automatic access(input string req, input logic [23:0] a, input logic v, input logic rb,
                        input logic expSel, input logic expIgn, input logic [13:0] expOff,
                        input logic chkOff);
    busAddr = a; busValid = v; regBlockHit = rb;
    @(negedge clk);
    check({req, " valid"}, outValid, v);
    check({req, " sel"}, arraySel, expSel);
    check({req, " ignored"}, ignoredAccess, expIgn);
    if (chkOff) check({req, " offset"}, arrayOffset, expOff);
    busValid = 1'b0; regBlockHit = 1'b0;
  endtask

  task automatic writeBase(input logic [23:0] b);
    baseWrEn = 1'b1; baseWrData = b;
    @(negedge clk);
    baseWrEn = 1'b0;
  endtask

  task automatic doReset(input logic [23:0] sb);
    busValid = 1'b0; regBlockHit = 1'b0;
    @(negedge clk);
    rstN = 1'b0; shadowBase = sb;
    @(negedge clk); @(negedge clk);
    check("R1 outValid", outValid, 0);
    check("R1 sel", arraySel, 0);
    check("R1 ignored", ignoredAccess, 0);
    check("R1 offset", arrayOffset, 0);
    rstN = 1'b1;
  endtask

  task automatic tShadowLoad_r2();
    doReset(24'h012000);
    // write on the load edge must be dropped; access on the load edge must not select
    baseWrEn = 1'b1; baseWrData = 24'h040000;
    access("R2 load edge", 24'h012000, 1, 0, 0, 0, 0, 0);
    baseWrEn = 1'b0;
    access("R2 shadow base", 24'h012000, 1, 0, 1, 0, 14'h0000, 1);
  endtask

  task automatic tWindow_r3_r4();
    access("R3 low edge", 24'h012000, 1, 0, 1, 0, 14'h0000, 1);
    access("R3 high edge", 24'h015FFF, 1, 0, 1, 0, 14'h3FFF, 1);
    access("R3 below", 24'h011FFF, 1, 0, 0, 0, 0, 0);
    access("R3 above", 24'h016000, 1, 0, 0, 0, 0, 0);
    access("R4 middle", 24'h013456, 1, 0, 1, 0, 14'h1456, 1);
  endtask

  task automatic tAlign_r5_r11();
    writeBase(24'h0207FF);
    access("R5 R11 new base", 24'h020000, 1, 0, 1, 0, 14'h0000, 1);
    access("R5 offset 7FF", 24'h0207FF, 1, 0, 1, 0, 14'h07FF, 1);
    access("R5 below", 24'h01FFFF, 1, 0, 0, 0, 0, 0);
    access("R11 old base", 24'h012000, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic tMirror_r6();
    writeBase(24'hFFC000);
    access("R6 mirrored hit", 24'h0FC010, 1, 0, 1, 0, 14'h0010, 1);
    access("R6 bit19 low", 24'h07C010, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic tUnreachable_r7();
    writeBase(24'h100000);
    access("R7 base 100000 a", 24'h100000, 1, 0, 0, 0, 0, 0);
    access("R7 base 100000 b", 24'h180000, 1, 0, 0, 0, 0, 0);
    writeBase(24'hF7F800);
    access("R7 base F7F800", 24'hF80000, 1, 0, 0, 0, 0, 0);
    writeBase(24'h012000);
    access("R7 restored", 24'h012000, 1, 0, 1, 0, 14'h0000, 1);
  endtask

  task automatic tPriority_r8_r9_r10();
    access("R8 overlap", 24'h012100, 1, 1, 0, 1, 0, 0);
    access("R8 one cycle", 24'h012100, 1, 0, 1, 0, 14'h0100, 1);
    access("R9 outside", 24'h030000, 1, 1, 0, 0, 0, 0);
    access("R9 R10 idle", 24'h012100, 0, 1, 0, 0, 0, 0);
    access("R10 idle in window", 24'h012000, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic tShadowLatch_r11();
    shadowBase = 24'h050000;
    access("R11 shadow not live", 24'h050000, 1, 0, 0, 0, 0, 0);
    access("R11 base kept", 24'h012000, 1, 0, 1, 0, 14'h0000, 1);
    doReset(24'h050000);
    access("R11 load edge", 24'h050000, 1, 0, 0, 0, 0, 0);
    access("R11 new shadow", 24'h050000, 1, 0, 1, 0, 14'h0000, 1);
  endtask

  initial begin
    fork
      begin
        tShadowLoad_r2();
        tWindow_r3_r4();
        tAlign_r5_r11();
        tMirror_r6();
        tUnreachable_r7();
        tPriority_r8_r9_r10();
        tShadowLatch_r11();
      end
      begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule